// File: doc/BRIEF.md
# Speculative Cache-Enable Generator

This block drives the active-low cache-enable line of a processor bus in which every cycle opens with one address state (T1) followed by one or more data states (T2), and reads may be returned as four-transfer bursts. The processor needs the enable already valid in the first T2, but a cacheability answer from an asynchronous address decoder is only trustworthy after it has crossed a synchronizer. So the block drives the enable low as soon as a read cycle starts. This lets a possibly cacheable read turn into a line fill. In parallel it settles the real answer. If the cycle turns out not to be cacheable, the block pulls the enable back high before the processor's later sampling point.

The cacheability answer combines three things. The first is the external region-decode input, passed through a flop chain. The second is a match of the latched cycle address against a parameterised region. The third is an optional rule that only code fetches are cached. During the burst the block counts ready strobes. It raises a capture flag for the external cache on each beat of a read that was kept cacheable. The cycle closes on the ready strobe that comes with the last-transfer indication.

Top module: `cache_enable_gen`

## Requirements
- R1: While reset is held and on the first clock after it, `ken_n` is 1 and `fill_capture` is 0.
- R2: While the bus is idle and through every cycle of a write (started with `w_r` = 1), `ken_n` stays 1 and `fill_capture` stays 0, even if `brdy_n` is driven low.
- R3: A cycle starts when `ads_n` is sampled 0 while idle. For a read (`w_r` = 0), `ken_n` is 0 in T2 states 1 through DECIDE_T2 (default 2), whatever the decode inputs.
- R4: A read is cacheable only if three conditions hold. `region_hit`, sampled at the end of T1 through a SYNC_STAGES-deep flop chain, is 1. `(addr & REGION_MASK) == (REGION_BASE & REGION_MASK)` for the address latched with the strobe. Either `d_c` = 0 (code fetch) or CACHE_DATA = 1 (`d_c` = 1 means a data read). Changes of `region_hit` after T1 do not alter the answer.
- R5: A non-cacheable read has `ken_n` = 1 from T2 number DECIDE_T2+1 to the end of the cycle.
- R6: A cacheable read keeps `ken_n` = 0 until the cycle ends.
- R7: A cycle ends on the clock edge where `brdy_n` and `blast_n` are both 0. In the following clock, `ken_n` is 1 and a new strobe is accepted.
- R8: `fill_capture` is 1 exactly while `brdy_n` is 0 in a cacheable read after the decision point, and only for the first BEATS (default 4) ready strobes of the cycle.
- R9: An `ads_n` pulse during an active cycle is ignored. The running read keeps its `ken_n` and capture behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ads_n | input | 1 | Address strobe, active low, marks T1 |
| addr | input | ADDR_W | Cycle address, valid with the strobe |
| w_r | input | 1 | 1 = write cycle, 0 = read cycle |
| d_c | input | 1 | 1 = data access, 0 = code fetch |
| region_hit | input | 1 | Asynchronous external cacheable-region decode, 1 = cacheable |
| brdy_n | input | 1 | Burst ready, one low clock per transfer |
| blast_n | input | 1 | Last transfer indication, active low |
| ken_n | output | 1 | Cache enable to the processor, active low |
| fill_capture | output | 1 | Tells the external cache to store the current beat |

## Verification
The bench builds the block with a 16-bit address, a cacheable window at 0x4000–0x7FFF, a two-flop synchronizer, the decision at the end of the second T2, a four-beat line and CACHE_DATA = 0. Code-only caching lets a single instance show both outcomes for in-region reads: a code fetch is kept and a data read is dropped. The narrow window lets one address bit push a read out of region. Bursts of five transfers, zero-wait single transfers and slow first beats reach the beat limit, the end of a cycle before the decision point, and the capture boundary at the third T2.

// File: rtl/cen_pkg.sv
// Shared types for the speculative cache-enable generator.
package cen_pkg;

    // Bus-cycle tracking states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // no cycle in progress
        ST_RSPEC = 3'd1,  // read, enable driven speculatively
        ST_RKEEP = 3'd2,  // read, decided cacheable
        ST_RDROP = 3'd3,  // read, decided non-cacheable
        ST_WRITE = 3'd4   // write cycle
    } bus_state_t;

endpackage

// File: rtl/cen_sync.sv
// Multi-flop synchronizer for the asynchronous region-decode input.
// Assumes: STAGES >= 1; the input may change at any time relative to clk.
module cen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES == 1) begin : g_single
            logic s_r;
            // Single register stage.
            always_ff @(posedge clk) begin
                if (!rst_n) s_r <= 1'b0;
                else        s_r <= d;
            end
            assign q = s_r;
        end else begin : g_chain
            logic [STAGES-1:0] chain_r;
            // Shift the input through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_r <= '0;
                else        chain_r <= {chain_r[STAGES-2:0], d};
            end
            assign q = chain_r[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/cen_region.sv
// Latches the cycle attributes at the address strobe and compares the
// latched address with the parameterised cacheable window.
// Assumes: addr and d_c are valid in the clock where capture is high.
module cen_region #(
    parameter int                ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = '0,
    parameter logic [ADDR_W-1:0] MASK   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr,
    input  logic              d_c,
    output logic              in_region,
    output logic              is_data
);

    localparam logic [ADDR_W-1:0] MATCH = BASE & MASK;

    logic [ADDR_W-1:0] addr_q;

    // Hold address and access class for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            is_data <= 1'b0;
        end else if (capture) begin
            addr_q  <= addr;
            is_data <= d_c;
        end
    end

    // Window compare on the latched address.
    always_comb begin
        in_region = ((addr_q & MASK) == MATCH);
    end

endmodule

// File: rtl/cen_counters.sv
// Counts T2 states since the strobe and ready strobes within a cycle.
// Both counters saturate at their all-ones value.
// Assumes: start and busy are never high together.
module cen_counters #(
    parameter int T2_W   = 2,
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              busy,
    input  logic              brdy_n,
    output logic [T2_W-1:0]   t2cnt,
    output logic [BEAT_W-1:0] beats
);

    localparam logic [T2_W-1:0]   T2_MAX   = '1;
    localparam logic [BEAT_W-1:0] BEAT_MAX = '1;

    // T2 index: 1 in the first T2, then one per clock.
    always_ff @(posedge clk) begin
        if (!rst_n)                       t2cnt <= '0;
        else if (start)                   t2cnt <= T2_W'(1);
        else if (busy && t2cnt != T2_MAX) t2cnt <= t2cnt + 1'b1;
    end

    // Number of ready strobes already taken in this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    beats <= '0;
        else if (start)                                beats <= '0;
        else if (busy && !brdy_n && beats != BEAT_MAX) beats <= beats + 1'b1;
    end

endmodule

// File: rtl/cache_enable_gen.sv
// Speculative cache-enable generator. Drives ken_n low from the first T2
// of every read and withdraws it after DECIDE_T2 T2 states if the
// synchronized decode says the cycle is not cacheable.
// Assumes: region_hit is stable from T1 for at least SYNC_STAGES clocks;
// DECIDE_T2 >= SYNC_STAGES; cycles are not pipelined.
module cache_enable_gen
    import cen_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                SYNC_STAGES = 2,
    parameter int                DECIDE_T2   = 2,
    parameter int                BEATS       = 4,
    parameter bit                CACHE_DATA  = 1'b1,
    parameter logic [ADDR_W-1:0] REGION_BASE = '0,
    parameter logic [ADDR_W-1:0] REGION_MASK = {1'b1, {(ADDR_W-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ads_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              w_r,
    input  logic              d_c,
    input  logic              region_hit,
    input  logic              brdy_n,
    input  logic              blast_n,
    output logic              ken_n,
    output logic              fill_capture
);

    localparam int                T2_W      = $clog2(DECIDE_T2 + 2);
    localparam int                BEAT_W    = $clog2(BEATS + 1);
    localparam logic [T2_W-1:0]   DECIDE_AT = T2_W'(DECIDE_T2);
    localparam logic [BEAT_W-1:0] BEAT_LIM  = BEAT_W'(BEATS);

    bus_state_t        state, state_nx;
    logic              start, busy, last_beat, decide, cacheable;
    logic              hit_sync, in_region, is_data;
    logic [T2_W-1:0]   t2cnt;
    logic [BEAT_W-1:0] beats;

    assign start     = (state == ST_IDLE) && !ads_n;
    assign busy      = (state != ST_IDLE);
    assign last_beat = !brdy_n && !blast_n;
    assign decide    = (state == ST_RSPEC) && (t2cnt == DECIDE_AT);

    cen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (region_hit),
        .q     (hit_sync)
    );

    cen_region #(
        .ADDR_W (ADDR_W),
        .BASE   (REGION_BASE),
        .MASK   (REGION_MASK)
    ) u_region (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (start),
        .addr      (addr),
        .d_c       (d_c),
        .in_region (in_region),
        .is_data   (is_data)
    );

    cen_counters #(.T2_W(T2_W), .BEAT_W(BEAT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .busy   (busy),
        .brdy_n (brdy_n),
        .t2cnt  (t2cnt),
        .beats  (beats)
    );

    // Final cacheability answer from the three qualifying conditions.
    always_comb begin
        cacheable = hit_sync && in_region && (!is_data || CACHE_DATA);
    end

    // Next-state selection for the bus-cycle tracker.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = w_r ? ST_WRITE : ST_RSPEC;
            ST_RSPEC: begin
                if (last_beat)   state_nx = ST_IDLE;
                else if (decide) state_nx = cacheable ? ST_RKEEP : ST_RDROP;
            end
            ST_RKEEP, ST_RDROP, ST_WRITE: if (last_beat) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Registered enable output: low only in speculative or kept reads.
    always_ff @(posedge clk) begin
        if (!rst_n) ken_n <= 1'b1;
        else        ken_n <= !((state_nx == ST_RSPEC) || (state_nx == ST_RKEEP));
    end

    // Capture strobe for each kept beat within the line length.
    always_comb begin
        fill_capture = (state == ST_RKEEP) && !brdy_n && (beats < BEAT_LIM);
    end

endmodule

// File: rtl/cen_chk.sv
// Property checker for cache_enable_gen, attached through bind.
module cen_chk
    import cen_pkg::*;
#(
    parameter int BEAT_W = 3,
    parameter int BEATS  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ads_n,
    input logic              w_r,
    input logic              brdy_n,
    input logic              blast_n,
    input logic              ken_n,
    input logic              fill_capture,
    input bus_state_t        state,
    input logic [BEAT_W-1:0] beats
);

    // R2
    idle_write_ken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_WRITE) |-> (ken_n && !fill_capture));

    // R3
    spec_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !ads_n && !w_r) |=> !ken_n);

    // R3
    spec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RSPEC) |-> !ken_n);

    // R5
    drop_ken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDROP) |-> ken_n);

    // R7
    cycle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !brdy_n && !blast_n) |=> (state == ST_IDLE && ken_n));

    // R8
    capture_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_capture |-> (!brdy_n && !ken_n));

    // R8
    capture_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_capture |-> (int'(beats) < BEATS));

    // R9
    stray_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RKEEP && !ads_n && !(!brdy_n && !blast_n)) |=> (state == ST_RKEEP));

endmodule

bind cache_enable_gen cen_chk #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ads_n        (ads_n),
    .w_r          (w_r),
    .brdy_n       (brdy_n),
    .blast_n      (blast_n),
    .ken_n        (ken_n),
    .fill_capture (fill_capture),
    .state        (state),
    .beats        (beats)
);

// File: tb/cache_enable_gen_test.sv
`timescale 1ns/1ps
module cache_enable_gen_test;

    localparam int DECIDE = 2;
    localparam int NBEATS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ads_n = 1'b1;
    logic [15:0] addr = '0;
    logic        w_r = 1'b0;
    logic        d_c = 1'b0;
    logic        region_hit = 1'b0;
    logic        brdy_n = 1'b1;
    logic        blast_n = 1'b1;
    logic        ken_n;
    logic        fill_capture;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cache_enable_gen #(
        .ADDR_W      (16),
        .SYNC_STAGES (2),
        .DECIDE_T2   (DECIDE),
        .BEATS       (NBEATS),
        .CACHE_DATA  (1'b0),
        .REGION_BASE (16'h4000),
        .REGION_MASK (16'hC000)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ads_n        (ads_n),
        .addr         (addr),
        .w_r          (w_r),
        .d_c          (d_c),
        .region_hit   (region_hit),
        .brdy_n       (brdy_n),
        .blast_n      (blast_n),
        .ken_n        (ken_n),
        .fill_capture (fill_capture)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Read cycle: a = address, dc = data flag, hit = decode, w = wait
    // states before first beat, n = transfers, stray = extra strobe at T2 2.
    task automatic run_read(input logic [15:0] a, input bit dc, input bit hit,
                            input int w, input int n, input bit stray, input string tag);
        bit keep;
        int beat;
        int k;
        bit done;
        keep = hit && ((a & 16'hC000) == 16'h4000) && !dc;
        @(negedge clk);
        ads_n = 1'b0; w_r = 1'b0; d_c = dc; addr = a; region_hit = hit;
        @(negedge clk);
        beat = 0; k = 1; done = 1'b0;
        while (!done) begin
            if (k <= DECIDE) chk({tag, " R3 speculative ken"}, int'(ken_n), 0);
            else if (keep)   chk({tag, " R6 kept ken"}, int'(ken_n), 0);
            else             chk({tag, " R5 withdrawn ken"}, int'(ken_n), 1);
            ads_n = (stray && k == 2) ? 1'b0 : 1'b1;
            w_r   = (stray && k == 2);
            if (k == 2) region_hit = ~hit;   // R4: late decode change ignored
            if (k > w) begin
                beat++;
                brdy_n  = 1'b0;
                blast_n = (beat == n) ? 1'b0 : 1'b1;
            end else begin
                brdy_n  = 1'b1;
                blast_n = 1'b1;
            end
            #1;
            chk({tag, " R8 capture"}, int'(fill_capture),
                int'(!brdy_n && k > DECIDE && keep && beat <= NBEATS));
            if (beat == n) done = 1'b1;
            else begin
                @(negedge clk);
                k++;
            end
        end
        @(negedge clk);
        brdy_n = 1'b1; blast_n = 1'b1; ads_n = 1'b1; w_r = 1'b0;
        chk({tag, " R7 end ken high"}, int'(ken_n), 1);
        #1;
        chk({tag, " R7 end capture low"}, int'(fill_capture), 0);
    endtask

    task automatic run_write(input int w, input int n);
        int beat;
        int k;
        bit done;
        @(negedge clk);
        ads_n = 1'b0; w_r = 1'b1; d_c = 1'b1; addr = 16'h4400; region_hit = 1'b1;
        @(negedge clk);
        ads_n = 1'b1;
        beat = 0; k = 1; done = 1'b0;
        while (!done) begin
            chk("R2 write ken", int'(ken_n), 1);
            if (k > w) begin
                beat++;
                brdy_n = 1'b0;
                blast_n = (beat == n) ? 1'b0 : 1'b1;
            end
            #1;
            chk("R2 write capture", int'(fill_capture), 0);
            if (beat == n) done = 1'b1;
            else begin
                @(negedge clk);
                k++;
            end
        end
        @(negedge clk);
        brdy_n = 1'b1; blast_n = 1'b1; w_r = 1'b0;
        chk("R7 after write ken", int'(ken_n), 1);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk("R1 reset ken", int'(ken_n), 1);
        chk("R1 reset capture", int'(fill_capture), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 post-reset ken", int'(ken_n), 1);
    endtask

    task automatic test_idle();
        brdy_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R2 idle ken", int'(ken_n), 1);
        chk("R2 idle capture", int'(fill_capture), 0);
        brdy_n = 1'b1;
        @(negedge clk);
        chk("R2 idle ken after strobe", int'(ken_n), 1);
    endtask

    initial begin
        test_reset();
        test_idle();
        run_read(16'h4120, 1'b0, 1'b1, 1, 4, 1'b0, "code-kept");
        run_read(16'h4120, 1'b0, 1'b0, 1, 4, 1'b0, "R4 decode-miss");
        run_read(16'h8120, 1'b0, 1'b1, 0, 4, 1'b0, "R4 out-of-window");
        run_read(16'h5000, 1'b1, 1'b1, 2, 4, 1'b0, "R4 data-read");
        run_write(2, 1);
        run_write(0, 4);
        run_read(16'h4000, 1'b0, 1'b1, 0, 1, 1'b0, "single-zero-wait");
        run_read(16'h7FF0, 1'b0, 1'b1, 0, 4, 1'b1, "R9 stray-strobe");
        run_read(16'h4200, 1'b0, 1'b1, 0, 5, 1'b0, "R8 over-length");
        run_read(16'h4300, 1'b0, 1'b0, 3, 2, 1'b1, "R9 stray-drop");
        test_idle();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule